// File: doc/BRIEF.md
# SD Host Global Register Front End

This block sits between a 32-bit register bus and one or two SD host slot controllers. It decodes a 4 KiB register window. The lowest 256 bytes hold a small global register file: a controller information word, a debounce setting, a bus setting, write-protect polarity, card detect and interrupt status. Each slot owns a 256-byte window above that. Accesses to a slot window go out on that slot's register port, and the slot's answer comes back through the same response channel.

The global page also holds writable shadow copies of each slot's capability word and maximum-current word. These copies drive dedicated output ports so the slot logic can consume them. Each slot's interrupt line is sampled into the status register, and one combined interrupt output is raised while any slot is requesting.

The number of slots is a parameter of value 1 or 2. It changes the reset value of the information word and decides which windows and aliases exist. Only aligned 32-bit accesses are decoded. Every accepted access receives exactly one response.

Top module: `sdfront_top`

## Requirements
- R1: After reset, the information word (offset 0x000) reads 0x00010000 with one slot and 0x00030000 with two slots. The debounce word (0x004) reads 0x00000005. Bus (0x008), write-protect polarity (0x0EC), card detect (0x0F0) and interrupt status (0x0FC) read 0. Each capability word reads `CAP_DEFAULT`, each maximum-current word reads 0, and `irq` is low.
- R2: Writing the information word stores every written bit except bit 0, which always reads back 0.
- R3: The words at 0x004, 0x008, 0x0EC and 0x0F0 are plain 32-bit read/write registers.
- R4: Offsets 0x010 and 0x018 access slot 0's capability and maximum-current words. Offsets 0x020 and 0x028 do the same for slot 1, and only exist when two slots are configured. The stored values appear on `slot_cap` and `slot_maxcur`, with slot n in bits [32n+31:32n].
- R5: An access to 0x100*(n+1)..0x100*(n+1)+0xFF, for a slot n that exists, is forwarded to slot n with address bits [7:0]. Only one slot request is active at a time. No new access is accepted until that slot has responded, and the slot's response data returns on `rsp_rdata`.
- R6: Interrupt status bit n equals `slot_irq[n]` as sampled at the previous clock edge. Writes to 0x0FC have no effect.
- R7: `irq` is high exactly when at least one interrupt status bit is set.
- R8: A misaligned address, an unlisted global offset, an alias of a missing slot, or a window above the last slot is unmapped. Reads of it return 0, writes to it change nothing, and its response carries `rsp_err` high for that one response cycle.
- R9: A global access accepted at a clock edge gets its response (`rsp_valid` high) in the cycle after that edge. `req_ready` is high for global accesses whenever no slot access is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Request accepted at this edge when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address within the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one per accepted access |
| rsp_rdata | output | 32 | Read data (0 for global writes) |
| rsp_err | output | 1 | Unmapped access flag, valid with rsp_valid |
| slot_req_valid | output | NSLOT | Per-slot request |
| slot_req_write | output | 1 | Forwarded write flag |
| slot_req_addr | output | 8 | Forwarded offset within the slot window |
| slot_req_wdata | output | 32 | Forwarded write data |
| slot_req_ready | input | NSLOT | Slot accepts its request |
| slot_rsp_valid | input | NSLOT | Slot response strobe |
| slot_rsp_rdata | input | 32*NSLOT | Slot response data |
| slot_irq | input | NSLOT | Slot interrupt levels |
| slot_cap | output | 32*NSLOT | Capability word copies |
| slot_maxcur | output | 32*NSLOT | Maximum-current word copies |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is two slot interrupt lines changing independently while the status word is being read. A stale or cross-wired status bit only shows up when the lines are in asymmetric patterns. The bench steps `slot_irq` through 01, 11, 10 and 00, reading the status word and sampling `irq` after each step. It then writes all ones to the status offset with both lines low, to show that the write is ignored. Slot forwarding uses a slot model with a two-cycle response, so that the bench can see that new requests are held off while a slot access is outstanding.

// File: rtl/sdfront_pkg.sv
package sdfront_pkg;
  localparam int AW       = 12;
  localparam int DW       = 32;
  localparam int WIN_AW   = 8;
  localparam int PAGE_W   = AW - WIN_AW;
  localparam int SLOT_MAX = 2;

  localparam logic [WIN_AW-1:0] OFS_INFO     = 8'h00;
  localparam logic [WIN_AW-1:0] OFS_DEBOUNCE = 8'h04;
  localparam logic [WIN_AW-1:0] OFS_BUS      = 8'h08;
  localparam logic [WIN_AW-1:0] OFS_CAP0     = 8'h10;
  localparam logic [WIN_AW-1:0] OFS_MAXC0    = 8'h18;
  localparam logic [WIN_AW-1:0] OFS_CAP1     = 8'h20;
  localparam logic [WIN_AW-1:0] OFS_MAXC1    = 8'h28;
  localparam logic [WIN_AW-1:0] OFS_WPPOL    = 8'hEC;
  localparam logic [WIN_AW-1:0] OFS_CDET     = 8'hF0;
  localparam logic [WIN_AW-1:0] OFS_ISTAT    = 8'hFC;

  localparam logic [DW-1:0] DEBOUNCE_RST = 32'h0000_0005;

  typedef enum logic [3:0] {
    K_NONE, K_INFO, K_DEBOUNCE, K_BUS, K_WPPOL, K_CDET,
    K_ISTAT, K_CAP, K_MAXC, K_SLOT
  } fd_kind_e;

  function automatic logic [DW-1:0] info_reset_val(input int nslot);
    logic [DW-1:0] v;
    v = '0;
    v[16] = 1'b1;
    if (nslot > 1) v[17] = 1'b1;
    return v;
  endfunction

  function automatic logic [DW-1:0] info_write_val(input logic [DW-1:0] w);
    return w & ~DW'(1);
  endfunction

  function automatic logic slot_of_page(input logic [PAGE_W-1:0] page);
    logic [PAGE_W-1:0] s;
    s = page - PAGE_W'(1);
    return s[0];
  endfunction
endpackage

// File: rtl/sdfront_decode.sv
module sdfront_decode
  import sdfront_pkg::*;
#(
  parameter int NSLOT = 2
) (
  input  logic [AW-1:0] addr,
  output fd_kind_e      kind,
  output logic          idx
);
  logic [PAGE_W-1:0] page;
  logic [WIN_AW-1:0] off;

  assign page = addr[AW-1:WIN_AW];
  assign off  = addr[WIN_AW-1:0];

  always_comb begin
    kind = K_NONE;
    idx  = 1'b0;
    if (addr[1:0] == 2'b00) begin
      if (page == '0) begin
        case (off)
          OFS_INFO:     kind = K_INFO;
          OFS_DEBOUNCE: kind = K_DEBOUNCE;
          OFS_BUS:      kind = K_BUS;
          OFS_WPPOL:    kind = K_WPPOL;
          OFS_CDET:     kind = K_CDET;
          OFS_ISTAT:    kind = K_ISTAT;
          OFS_CAP0:     kind = K_CAP;
          OFS_MAXC0:    kind = K_MAXC;
          OFS_CAP1: if (NSLOT > 1) begin
            kind = K_CAP;
            idx  = 1'b1;
          end
          OFS_MAXC1: if (NSLOT > 1) begin
            kind = K_MAXC;
            idx  = 1'b1;
          end
          default: kind = K_NONE;
        endcase
      end else if (int'(page) <= NSLOT) begin
        kind = K_SLOT;
        idx  = slot_of_page(page);
      end
    end
  end
endmodule

// File: rtl/sdfront_regs.sv
module sdfront_regs
  import sdfront_pkg::*;
#(
  parameter int            NSLOT       = 2,
  parameter logic [DW-1:0] CAP_DEFAULT = 32'h0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  fd_kind_e            kind,
  input  logic                idx,
  input  logic [DW-1:0]       wdata,
  input  logic [NSLOT-1:0]    istat,
  output logic [DW-1:0]       rdata,
  output logic [NSLOT*DW-1:0] caps,
  output logic [NSLOT*DW-1:0] maxcs
);
  localparam logic [DW-1:0] INFO_RST = info_reset_val(NSLOT);

  logic [DW-1:0] info_q, deb_q, bus_q, wp_q, cd_q;
  logic [DW-1:0] cap_ext [SLOT_MAX];
  logic [DW-1:0] mc_ext  [SLOT_MAX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      info_q <= INFO_RST;
      deb_q  <= DEBOUNCE_RST;
      bus_q  <= '0;
      wp_q   <= '0;
      cd_q   <= '0;
    end else if (we) begin
      case (kind)
        K_INFO:     info_q <= info_write_val(wdata);
        K_DEBOUNCE: deb_q  <= wdata;
        K_BUS:      bus_q  <= wdata;
        K_WPPOL:    wp_q   <= wdata;
        K_CDET:     cd_q   <= wdata;
        default: ;
      endcase
    end
  end

  for (genvar n = 0; n < SLOT_MAX; n++) begin : g_slot
    if (n < NSLOT) begin : g_on
      logic [DW-1:0] cap_q, mc_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cap_q <= CAP_DEFAULT;
          mc_q  <= '0;
        end else if (we && idx == 1'(n)) begin
          if (kind == K_CAP)  cap_q <= wdata;
          if (kind == K_MAXC) mc_q  <= wdata;
        end
      end
      assign cap_ext[n]         = cap_q;
      assign mc_ext[n]          = mc_q;
      assign caps[n*DW +: DW]   = cap_q;
      assign maxcs[n*DW +: DW]  = mc_q;
    end else begin : g_off
      assign cap_ext[n] = '0;
      assign mc_ext[n]  = '0;
    end
  end

  always_comb begin
    case (kind)
      K_INFO:     rdata = info_q;
      K_DEBOUNCE: rdata = deb_q;
      K_BUS:      rdata = bus_q;
      K_WPPOL:    rdata = wp_q;
      K_CDET:     rdata = cd_q;
      K_ISTAT:    rdata = DW'(istat);
      K_CAP:      rdata = cap_ext[idx];
      K_MAXC:     rdata = mc_ext[idx];
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/sdfront_irq.sv
module sdfront_irq #(
  parameter int NSLOT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] slot_irq,
  output logic [NSLOT-1:0] stat,
  output logic             irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= slot_irq;
  end

  assign irq = |stat;
endmodule

// File: rtl/sdfront_top.sv
module sdfront_top
  import sdfront_pkg::*;
#(
  parameter int            NSLOT       = 2,
  parameter logic [DW-1:0] CAP_DEFAULT = 32'h3A5C_0081
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [AW-1:0]       req_addr,
  input  logic [DW-1:0]       req_wdata,
  output logic                rsp_valid,
  output logic [DW-1:0]       rsp_rdata,
  output logic                rsp_err,
  output logic [NSLOT-1:0]    slot_req_valid,
  output logic                slot_req_write,
  output logic [WIN_AW-1:0]   slot_req_addr,
  output logic [DW-1:0]       slot_req_wdata,
  input  logic [NSLOT-1:0]    slot_req_ready,
  input  logic [NSLOT-1:0]    slot_rsp_valid,
  input  logic [NSLOT*DW-1:0] slot_rsp_rdata,
  input  logic [NSLOT-1:0]    slot_irq,
  output logic [NSLOT*DW-1:0] slot_cap,
  output logic [NSLOT*DW-1:0] slot_maxcur,
  output logic                irq
);
  fd_kind_e         kind;
  logic             idx;
  logic [DW-1:0]    reg_rdata;
  logic [NSLOT-1:0] istat;

  logic             is_slot;
  logic             g_acc, s_acc, s_done;
  logic             pend_q, pend_idx_q;
  logic             g_rsp_q, g_err_q;
  logic [DW-1:0]    g_rdata_q;

  logic [SLOT_MAX-1:0] sready_ext, srsp_ext;
  logic [DW-1:0]       srdata_ext [SLOT_MAX];

  sdfront_decode #(.NSLOT(NSLOT)) u_dec (
    .addr (req_addr),
    .kind (kind),
    .idx  (idx)
  );

  sdfront_regs #(.NSLOT(NSLOT), .CAP_DEFAULT(CAP_DEFAULT)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (g_acc && req_write),
    .kind  (kind),
    .idx   (idx),
    .wdata (req_wdata),
    .istat (istat),
    .rdata (reg_rdata),
    .caps  (slot_cap),
    .maxcs (slot_maxcur)
  );

  sdfront_irq #(.NSLOT(NSLOT)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_irq (slot_irq),
    .stat     (istat),
    .irq      (irq)
  );

  assign is_slot = (kind == K_SLOT);

  for (genvar n = 0; n < SLOT_MAX; n++) begin : g_port
    if (n < NSLOT) begin : g_on
      assign sready_ext[n]     = slot_req_ready[n];
      assign srsp_ext[n]       = slot_rsp_valid[n];
      assign srdata_ext[n]     = slot_rsp_rdata[n*DW +: DW];
      assign slot_req_valid[n] = req_valid && !pend_q && is_slot && (idx == 1'(n));
    end else begin : g_off
      assign sready_ext[n] = 1'b0;
      assign srsp_ext[n]   = 1'b0;
      assign srdata_ext[n] = '0;
    end
  end

  assign req_ready = !pend_q && (!is_slot || sready_ext[idx]);
  assign g_acc     = req_valid && req_ready && !is_slot;
  assign s_acc     = req_valid && req_ready && is_slot;
  assign s_done    = pend_q && srsp_ext[pend_idx_q];

  assign slot_req_write = req_write;
  assign slot_req_addr  = req_addr[WIN_AW-1:0];
  assign slot_req_wdata = req_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_idx_q <= 1'b0;
    end else if (s_acc) begin
      pend_q     <= 1'b1;
      pend_idx_q <= idx;
    end else if (s_done) begin
      pend_q     <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g_rsp_q   <= 1'b0;
      g_err_q   <= 1'b0;
      g_rdata_q <= '0;
    end else begin
      g_rsp_q   <= g_acc;
      g_err_q   <= g_acc && (kind == K_NONE);
      g_rdata_q <= (g_acc && !req_write) ? reg_rdata : '0;
    end
  end

  assign rsp_valid = g_rsp_q || s_done;
  assign rsp_rdata = s_done ? srdata_ext[pend_idx_q] : g_rdata_q;
  assign rsp_err   = g_err_q;
endmodule

// File: rtl/sdfront_chk.sv
module sdfront_chk
  import sdfront_pkg::*;
#(
  parameter int NSLOT = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic [AW-1:0]    req_addr,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic [DW-1:0]    rsp_rdata,
  input logic             rsp_err,
  input logic [NSLOT-1:0] slot_req_valid,
  input logic [NSLOT-1:0] slot_irq,
  input logic             irq,
  input logic             g_acc,
  input logic             s_acc
);
  // R9
  glob_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    g_acc |=> rsp_valid);

  // R5
  one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_req_valid));

  // R5
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_acc |=> !req_ready);

  // R2
  info_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (g_acc && !req_write && req_addr == 12'h000) |=> !rsp_rdata[0]);

  // R8
  err_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);

  // R7
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(|slot_irq));

  // R6
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|slot_irq) |=> irq);
endmodule

bind sdfront_top sdfront_chk #(.NSLOT(NSLOT)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_write      (req_write),
  .req_addr       (req_addr),
  .req_ready      (req_ready),
  .rsp_valid      (rsp_valid),
  .rsp_rdata      (rsp_rdata),
  .rsp_err        (rsp_err),
  .slot_req_valid (slot_req_valid),
  .slot_irq       (slot_irq),
  .irq            (irq),
  .g_acc          (g_acc),
  .s_acc          (s_acc)
);

// File: tb/sim_sdfront_top.sv
`timescale 1ns/1ps
module sim_sdfront_top;
  localparam logic [31:0] CAPD = 32'h3A5C_0081;

  logic clk = 1'b0;
  always #2 clk = ~clk;
  logic rst_n;

  // two-slot instance
  logic        req_valid, req_ready, req_write, rsp_valid, rsp_err, irq;
  logic [11:0] req_addr;
  logic [31:0] req_wdata, rsp_rdata;
  logic [1:0]  s_valid, s_ready, s_rsp, sirq;
  logic        s_write;
  logic [7:0]  s_addr;
  logic [31:0] s_wdata;
  logic [63:0] s_rdata, cap, maxcur;

  // one-slot instance
  logic        b_valid, b_ready, b_write, b_rsp, b_err, b_irq;
  logic [11:0] b_addr;
  logic [31:0] b_wdata, b_rdata, b_cap, b_maxcur;
  logic        b_sv, b_sw;
  logic [7:0]  b_sa;
  logic [31:0] b_swd;

  sdfront_top #(.NSLOT(2), .CAP_DEFAULT(CAPD)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .slot_req_valid(s_valid), .slot_req_write(s_write), .slot_req_addr(s_addr),
    .slot_req_wdata(s_wdata), .slot_req_ready(s_ready),
    .slot_rsp_valid(s_rsp), .slot_rsp_rdata(s_rdata),
    .slot_irq(sirq), .slot_cap(cap), .slot_maxcur(maxcur), .irq(irq)
  );

  sdfront_top #(.NSLOT(1), .CAP_DEFAULT(CAPD)) u1 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(b_valid), .req_ready(b_ready), .req_write(b_write),
    .req_addr(b_addr), .req_wdata(b_wdata),
    .rsp_valid(b_rsp), .rsp_rdata(b_rdata), .rsp_err(b_err),
    .slot_req_valid(b_sv), .slot_req_write(b_sw), .slot_req_addr(b_sa),
    .slot_req_wdata(b_swd), .slot_req_ready(1'b1),
    .slot_rsp_valid(1'b0), .slot_rsp_rdata(32'h0),
    .slot_irq(1'b0), .slot_cap(b_cap), .slot_maxcur(b_maxcur), .irq(b_irq)
  );

  // slot model: accepts when idle, answers two edges later
  logic [1:0]  scnt [2];
  logic [31:0] sdat [2];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < 2; n++) begin
        scnt[n] <= 2'd0;
        sdat[n] <= 32'h0;
      end
    end else begin
      for (int n = 0; n < 2; n++) begin
        if (scnt[n] == 2'd0 && s_valid[n]) begin
          scnt[n] <= 2'd2;
          sdat[n] <= s_write ? s_wdata : {8'h50 | 8'(n), 16'h0, s_addr};
        end else if (scnt[n] != 2'd0) begin
          scnt[n] <= scnt[n] - 2'd1;
        end
      end
    end
  end
  assign s_ready = {scnt[1] == 2'd0, scnt[0] == 2'd0};
  assign s_rsp   = {scnt[1] == 2'd1, scnt[0] == 2'd1};
  assign s_rdata = {sdat[1], sdat[0]};

  int total = 0;
  int bad   = 0;

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct {
    logic        chk;
    logic [31:0] d;
    logic        e;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  // monitor: pop and compare every response of the two-slot instance
  always @(negedge clk) begin
    exp_t x;
    if (rst_n && rsp_valid) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R9 unexpected response", 64'(rsp_rdata), 64'h0);
      end else begin
        x = sbq.pop_front();
        if (x.chk) check(rsp_rdata == x.d, x.tag, 64'(rsp_rdata), 64'(x.d));
        check(rsp_err == x.e, {x.tag, " err"}, 64'(rsp_err), 64'(x.e));
      end
    end
  end

  // driver: push expectation, run one access, wait for its response
  task automatic xfer(input logic wr, input logic [11:0] a, input logic [31:0] wd,
                      input logic chk, input logic [31:0] ed, input logic ee,
                      input string tag);
    exp_t x;
    x.chk = chk; x.d = ed; x.e = ee; x.tag = tag;
    sbq.push_back(x);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    if (a[11:8] == 4'h0) begin
      @(negedge clk);
      check(rsp_valid == 1'b1, {"R9 response next cycle ", tag}, 64'(rsp_valid), 64'h1);
    end
    while (sbq.size() != 0) @(negedge clk);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] ed, input logic ee,
                    input string tag);
    xfer(1'b0, a, 32'h0, 1'b1, ed, ee, tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] wd, input logic ee,
                    input string tag);
    xfer(1'b1, a, wd, 1'b0, 32'h0, ee, tag);
  endtask

  task automatic rd1(input logic [11:0] a, input logic [31:0] ed, input logic ee,
                     input string tag);
    @(negedge clk);
    b_valid = 1'b1; b_write = 1'b0; b_addr = a;
    @(posedge clk);
    #1;
    b_valid = 1'b0;
    @(negedge clk);
    check(b_rsp == 1'b1, {tag, " valid"}, 64'(b_rsp), 64'h1);
    check(b_rdata == ed, tag, 64'(b_rdata), 64'(ed));
    check(b_err == ee, {tag, " err"}, 64'(b_err), 64'(ee));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 64'h0, 64'h1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sirq = 2'b00;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    b_valid = 1'b0; b_write = 1'b0; b_addr = '0; b_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values, both configurations
    check(irq == 1'b0, "R1 irq low", 64'(irq), 64'h0);
    check(cap == {CAPD, CAPD}, "R1 cap ports", cap, {CAPD, CAPD});
    check(maxcur == 64'h0, "R1 maxcur ports", maxcur, 64'h0);
    check(b_cap == CAPD, "R1 one-slot cap port", 64'(b_cap), 64'(CAPD));
    rd(12'h000, 32'h0003_0000, 1'b0, "R1 info two slots");
    rd(12'h004, 32'h0000_0005, 1'b0, "R1 debounce");
    rd(12'h008, 32'h0, 1'b0, "R1 bus");
    rd(12'h0EC, 32'h0, 1'b0, "R1 wp polarity");
    rd(12'h0F0, 32'h0, 1'b0, "R1 card detect");
    rd(12'h0FC, 32'h0, 1'b0, "R1 irq status");
    rd(12'h010, CAPD, 1'b0, "R1 cap slot0");
    rd(12'h018, 32'h0, 1'b0, "R1 maxcur slot0");
    rd(12'h020, CAPD, 1'b0, "R1 cap slot1");
    rd(12'h028, 32'h0, 1'b0, "R1 maxcur slot1");
    rd1(12'h000, 32'h0001_0000, 1'b0, "R1 info one slot");
    rd1(12'h020, 32'h0, 1'b1, "R8 one-slot alias of missing slot");
    rd1(12'h200, 32'h0, 1'b1, "R8 one-slot window of missing slot");

    // R2 self-clearing lsb
    wr(12'h000, 32'hDEAD_BEEF, 1'b0, "R2 info write");
    rd(12'h000, 32'hDEAD_BEEE, 1'b0, "R2 info lsb reads 0");
    wr(12'h000, 32'h0000_0001, 1'b0, "R2 info write lsb only");
    rd(12'h000, 32'h0, 1'b0, "R2 info after lsb only");

    // R3 plain registers
    wr(12'h004, 32'h1234_5678, 1'b0, "R3 debounce write");
    wr(12'h008, 32'hFFFF_0000, 1'b0, "R3 bus write");
    wr(12'h0EC, 32'h0000_00A5, 1'b0, "R3 wp write");
    wr(12'h0F0, 32'h5A5A_5A5A, 1'b0, "R3 cd write");
    rd(12'h004, 32'h1234_5678, 1'b0, "R3 debounce");
    rd(12'h008, 32'hFFFF_0000, 1'b0, "R3 bus");
    rd(12'h0EC, 32'h0000_00A5, 1'b0, "R3 wp");
    rd(12'h0F0, 32'h5A5A_5A5A, 1'b0, "R3 cd");

    // R4 aliased per-slot words
    wr(12'h010, 32'h1111_0001, 1'b0, "R4 cap0 write");
    wr(12'h018, 32'h2222_0002, 1'b0, "R4 maxc0 write");
    wr(12'h020, 32'h3333_0003, 1'b0, "R4 cap1 write");
    wr(12'h028, 32'h4444_0004, 1'b0, "R4 maxc1 write");
    rd(12'h010, 32'h1111_0001, 1'b0, "R4 cap0");
    rd(12'h018, 32'h2222_0002, 1'b0, "R4 maxc0");
    rd(12'h020, 32'h3333_0003, 1'b0, "R4 cap1");
    rd(12'h028, 32'h4444_0004, 1'b0, "R4 maxc1");
    check(cap == {32'h3333_0003, 32'h1111_0001}, "R4 cap ports", cap,
          {32'h3333_0003, 32'h1111_0001});
    check(maxcur == {32'h4444_0004, 32'h2222_0002}, "R4 maxcur ports", maxcur,
          {32'h4444_0004, 32'h2222_0002});

    // R5 slot forwarding
    rd(12'h104, 32'h5000_0004, 1'b0, "R5 slot0 read");
    rd(12'h2F0, 32'h5100_00F0, 1'b0, "R5 slot1 read");
    xfer(1'b1, 12'h180, 32'hCAFE_0001, 1'b1, 32'hCAFE_0001, 1'b0, "R5 slot0 write");
    rd(12'h1FC, 32'h5000_00FC, 1'b0, "R5 slot0 top word");

    // R6 / R7 interrupt tracking
    @(negedge clk); sirq = 2'b01;
    @(negedge clk);
    check(irq == 1'b1, "R7 irq slot0", 64'(irq), 64'h1);
    rd(12'h0FC, 32'h1, 1'b0, "R6 status 01");
    @(negedge clk); sirq = 2'b11;
    rd(12'h0FC, 32'h3, 1'b0, "R6 status 11");
    @(negedge clk); sirq = 2'b10;
    @(negedge clk);
    check(irq == 1'b1, "R7 irq slot1 only", 64'(irq), 64'h1);
    rd(12'h0FC, 32'h2, 1'b0, "R6 status 10");
    @(negedge clk); sirq = 2'b00;
    @(negedge clk);
    check(irq == 1'b0, "R7 irq cleared", 64'(irq), 64'h0);
    wr(12'h0FC, 32'hFFFF_FFFF, 1'b0, "R6 status write");
    rd(12'h0FC, 32'h0, 1'b0, "R6 status write ignored");
    check(irq == 1'b0, "R7 irq after status write", 64'(irq), 64'h0);

    // R8 unmapped accesses
    rd(12'h00C, 32'h0, 1'b1, "R8 unlisted read");
    wr(12'h00C, 32'hFFFF_FFFF, 1'b1, "R8 unlisted write");
    rd(12'h00C, 32'h0, 1'b1, "R8 unlisted still 0");
    rd(12'h008, 32'hFFFF_0000, 1'b0, "R8 neighbour untouched");
    rd(12'h006, 32'h0, 1'b1, "R8 misaligned read");
    xfer(1'b0, 12'h300, 32'h0, 1'b1, 32'h0, 1'b1, "R8 window above slots");
    wr(12'h014, 32'h7777_7777, 1'b1, "R8 gap write");
    rd(12'h010, 32'h1111_0001, 1'b0, "R8 cap0 untouched");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule